// File: doc/BRIEF.md
# Inter-Processor Mailbox Channel Controller

A bank of mailbox channels that lets one processor post an eight-word message to another and learn when it has been taken. Each channel has a private 64-byte register window holding an owner word, a set of destination interrupt vectors, a vector mask, a mode/status word, a trigger, an acknowledge clear and the message words. All register writes are gated by a global key lock. While the lock is engaged, channel windows and the lock register can still be read.

A sender first unlocks the bank. It then claims an idle channel by writing its own one-hot acknowledge vector into the owner word. It selects the destination vectors, fills the message and fires the trigger with its own vector. The unmasked destination vectors are raised towards the remote side. When the remote side acknowledges, and automatic acknowledge is selected, the destination vectors drop and the owner's vector is raised instead. The sender clears that acknowledge, which leaves the channel ready for the next message. Writing zero to the owner word releases the channel back to idle.

The bus is a single-cycle register port. Writes take effect at the clock edge. Read data is combinational from the address. Interrupt vectors from all channels are OR-ed onto one output vector.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset, the lock register (byte offset 0xA00) reads 1 (engaged). Every channel register reads 0, except the mode word at window offset 0x10, which reads 0x10 (bit 4, idle). No interrupt vector is raised.
- R2: Writing 0x1ACCE551 to offset 0xA00 opens the lock, and the lock register then reads 0. Writing any other value engages the lock again, and it then reads 1.
- R3: While the lock is engaged, a write to any channel register changes nothing in that channel.
- R4: Channel n's window starts at n*0x40. Writing a nonzero value to the owner word (offset 0x00) of an idle channel stores it, and mode then reads bit 5 (ready). A nonzero owner write to a channel that is not idle is ignored. Writing zero clears the owner word and returns the channel to idle (mode 0x10).
- R5: A write to offset 0x04 ORs its bits into the destination set. A write to offset 0x08 clears the written bits. Offsets 0x04 and 0x0C both read the current set.
- R6: Writing the owner value to offset 0x1C while ready starts a send. From the next cycle, irq_out carries destination & ~mask, and mode reads no idle, ready or acknowledge bit. A trigger value other than the owner value is ignored.
- R7: Bits set in the mask word (offset 0x14, readable) keep the matching destination vectors from being raised.
- R8: Mode bit 0 is writable and selects automatic acknowledge. When it is set, a one-cycle remote_ack[n] pulse during a send sets mode bit 7, drops the destination vectors and raises the owner's vectors. When it is clear, the pulse has no effect.
- R9: Writing the owner value to offset 0x18 while acknowledged returns the channel to ready (bit 5) and drops the owner's vectors. Any other value is ignored.
- R10: Eight message words at offsets 0x20 to 0x3C can be written and read back independently in every channel.
- R11: irq_out is the bitwise OR of the vectors raised by all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| remote_ack | input | 32 | Acknowledge pulse from the remote side, one bit per channel |
| irq_out | output | 32 | Interrupt vectors, OR of all channels |

## Verification
A channel in the wrong state shows at once on the mode word read back, and on irq_out in the cycle after the offending write or acknowledge pulse. A dropped or misrouted write shows on the next read of the register it should have changed. For that reason every step of the claim, send, acknowledge and clear cycle is followed by a read of the mode word and a look at irq_out before the next stimulus. A lock that fails to gate writes shows as a changed destination set on the first read after a write made while the lock is engaged.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_SENT  = 2'd1,
      CH_ACKED = 2'd2,
      CH_READY = 2'd3
   } ch_state_e;

   localparam int unsigned IDX_OWNER = 0;
   localparam int unsigned IDX_DSET  = 1;
   localparam int unsigned IDX_DCLR  = 2;
   localparam int unsigned IDX_DSTAT = 3;
   localparam int unsigned IDX_MODE  = 4;
   localparam int unsigned IDX_MASK  = 5;
   localparam int unsigned IDX_ACLR  = 6;
   localparam int unsigned IDX_FIRE  = 7;
   localparam int unsigned IDX_MSG0  = 8;
endpackage

// File: rtl/mbx_lock.sv
module mbx_lock #(
   parameter int unsigned DW  = 32,
   parameter logic [DW-1:0] KEY = 32'h1ACC_E551
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          open_o
);
   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     open_q <= 1'b0;
      else if (wr_en) open_q <= (wr_data == KEY);
   end

   assign open_o = open_q;

   a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == KEY) |=> open_o);
   a_r2_bad_value_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data != KEY) |=> !open_o);
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
   import mbx_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned NDATA = 8,
   parameter int unsigned IDXW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lock_open,
   input  logic            wr_en,
   input  logic [IDXW-1:0] idx,
   input  logic [DW-1:0]   wr_data,
   input  logic            remote_ack,
   output logic [DW-1:0]   rd_data,
   output logic [DW-1:0]   irq_vec
);
   localparam int unsigned DIW = (NDATA > 1) ? $clog2(NDATA) : 1;

   ch_state_e      st_q;
   logic [DW-1:0]  owner_q, dset_q, mask_q;
   logic           auto_q;
   logic [DW-1:0]  msg_q [NDATA];
   logic           wr;
   logic [IDXW-1:0] moff;
   logic           msg_hit;

   assign wr      = wr_en && lock_open;
   assign moff    = idx - IDXW'(IDX_MSG0);
   assign msg_hit = (idx >= IDXW'(IDX_MSG0)) && (moff < IDXW'(NDATA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CH_IDLE;
         owner_q <= '0;
         dset_q  <= '0;
         mask_q  <= '0;
         auto_q  <= 1'b0;
      end else begin
         if (remote_ack && auto_q && st_q == CH_SENT) st_q <= CH_ACKED;
         if (wr) begin
            case (idx)
               IDXW'(IDX_OWNER): begin
                  if (wr_data == '0) begin
                     owner_q <= '0;
                     st_q    <= CH_IDLE;
                  end else if (st_q == CH_IDLE) begin
                     owner_q <= wr_data;
                     st_q    <= CH_READY;
                  end
               end
               IDXW'(IDX_DSET): dset_q <= dset_q | wr_data;
               IDXW'(IDX_DCLR): dset_q <= dset_q & ~wr_data;
               IDXW'(IDX_MODE): auto_q <= wr_data[0];
               IDXW'(IDX_MASK): mask_q <= wr_data;
               IDXW'(IDX_ACLR):
                  if (st_q == CH_ACKED && wr_data == owner_q) st_q <= CH_READY;
               IDXW'(IDX_FIRE):
                  if (st_q == CH_READY && wr_data == owner_q) st_q <= CH_SENT;
               default: ;
            endcase
         end
      end
   end

   generate
      for (genvar w = 0; w < NDATA; w++) begin : g_msg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) msg_q[w] <= '0;
            else if (wr && msg_hit && moff[DIW-1:0] == DIW'(w)) msg_q[w] <= wr_data;
         end
      end
   endgenerate

   always_comb begin
      case (idx)
         IDXW'(IDX_OWNER): rd_data = owner_q;
         IDXW'(IDX_DSET),
         IDXW'(IDX_DSTAT): rd_data = dset_q;
         IDXW'(IDX_MODE):  rd_data = {{(DW-8){1'b0}}, (st_q == CH_ACKED), 1'b0,
                                      (st_q == CH_READY), (st_q == CH_IDLE), 3'b000, auto_q};
         IDXW'(IDX_MASK):  rd_data = mask_q;
         default:          rd_data = msg_hit ? msg_q[moff[DIW-1:0]] : '0;
      endcase
   end

   assign irq_vec = ((st_q == CH_SENT)  ? (dset_q & ~mask_q) : '0)
                  | ((st_q == CH_ACKED) ? owner_q : '0);

   a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !lock_open) |=> ($stable(owner_q) && $stable(dset_q) && $stable(mask_q)
                                 && $stable(st_q) && $stable(auto_q)));
   a_r6_sent_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CH_SENT) |-> (owner_q != '0));
   a_r8_ack_after_send: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == CH_ACKED) |-> $past(st_q == CH_SENT && auto_q && remote_ack));
   a_r9_ack_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_q == CH_ACKED) |-> (st_q == CH_READY || st_q == CH_IDLE));
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
   parameter int unsigned NUM_CH   = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned NDATA    = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned LOCK_OFF = 'hA00,
   parameter logic [DW-1:0] KEY    = 32'h1ACC_E551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NUM_CH-1:0] remote_ack,
   output logic [DW-1:0]     irq_out
);
   localparam int unsigned WIN_BITS = 6;
   localparam int unsigned IDXW     = WIN_BITS - 2;
   localparam int unsigned CHW      = $clog2(NUM_CH);
   localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(NUM_CH * (1 << WIN_BITS));

   generate
      if (NUM_CH < 2) begin : g_err_ch
         $error("mbx_ctrl: NUM_CH must be at least 2");
      end
      if (NDATA + mbx_pkg::IDX_MSG0 > (1 << IDXW)) begin : g_err_data
         $error("mbx_ctrl: message words do not fit the channel window");
      end
      if (NUM_CH * (1 << WIN_BITS) > LOCK_OFF || LOCK_OFF >= (1 << ADDR_W)) begin : g_err_map
         $error("mbx_ctrl: lock register overlaps windows or is out of range");
      end
   endgenerate

   logic            ch_hit, lock_hit, lock_open;
   logic [CHW-1:0]  ch_sel;
   logic [IDXW-1:0] idx;
   logic [DW-1:0]   ch_rd  [NUM_CH];
   logic [DW-1:0]   ch_irq [NUM_CH];
   logic [1:0]      unused_lsb;

   assign unused_lsb = bus_addr[1:0];
   assign ch_hit   = bus_sel && ({1'b0, bus_addr} < WIN_END);
   assign lock_hit = bus_sel && (bus_addr == ADDR_W'(LOCK_OFF));
   assign ch_sel   = bus_addr[WIN_BITS+CHW-1:WIN_BITS];
   assign idx      = bus_addr[WIN_BITS-1:2];

   mbx_lock #(.DW(DW), .KEY(KEY)) lock_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lock_hit && bus_wr),
      .wr_data (bus_wdata),
      .open_o  (lock_open)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         mbx_channel #(.DW(DW), .NDATA(NDATA), .IDXW(IDXW)) ch_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .lock_open  (lock_open),
            .wr_en      (ch_hit && bus_wr && ch_sel == CHW'(c)),
            .idx        (idx),
            .wr_data    (bus_wdata),
            .remote_ack (remote_ack[c]),
            .rd_data    (ch_rd[c]),
            .irq_vec    (ch_irq[c])
         );
      end
   endgenerate

   always_comb begin
      if (lock_hit)    bus_rdata = {{(DW-1){1'b0}}, !lock_open};
      else if (ch_hit) bus_rdata = ch_rd[ch_sel];
      else             bus_rdata = '0;
   end

   always_comb begin
      irq_out = '0;
      for (int c = 0; c < NUM_CH; c++) irq_out = irq_out | ch_irq[c];
   end

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (irq_out == '0));
endmodule

// File: tb/mbx_ctrl_tb_top.sv
module mbx_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] KEY = 32'h1ACC_E551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] remote_ack = '0;
   logic [31:0] irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .remote_ack(remote_ack), .irq_out(irq_out)
   );

   function automatic logic [11:0] ca(input int ch, input int off);
      return 12'(ch * 64 + off);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic pulse_ack(input int ch);
      @(negedge clk);
      remote_ack[ch] = 1'b1;
      @(negedge clk);
      remote_ack[ch] = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(12'hA00, v);       check("R1 lock engaged", v, 32'h1);
      rd(ca(0, 'h10), v);   check("R1 mode idle", v, 32'h10);
      rd(ca(0, 'h00), v);   check("R1 owner zero", v, 32'h0);
      rd(ca(31, 'h0C), v);  check("R1 dest zero", v, 32'h0);
      check("R1 no irq", irq_out, 32'h0);
   endtask

   task automatic t_lock;
      logic [31:0] v;
      wr(ca(0, 'h04), 32'hFF);
      rd(ca(0, 'h0C), v);   check("R3 locked dest write ignored", v, 32'h0);
      wr(ca(0, 'h00), 32'h4);
      rd(ca(0, 'h10), v);   check("R3 locked claim ignored", v, 32'h10);
      wr(12'hA00, KEY);
      rd(12'hA00, v);       check("R2 key opens", v, 32'h0);
      wr(12'hA00, 32'h1234);
      rd(12'hA00, v);       check("R2 other value relocks", v, 32'h1);
      wr(12'hA00, KEY);
   endtask

   task automatic t_claim_dest;
      logic [31:0] v;
      wr(ca(0, 'h00), 32'h4);
      rd(ca(0, 'h00), v);   check("R4 owner stored", v, 32'h4);
      rd(ca(0, 'h10), v);   check("R4 ready after claim", v, 32'h20);
      wr(ca(0, 'h00), 32'h8);
      rd(ca(0, 'h00), v);   check("R4 second claim ignored", v, 32'h4);
      wr(ca(0, 'h04), 32'h3);
      wr(ca(0, 'h04), 32'h100);
      rd(ca(0, 'h0C), v);   check("R5 dest OR", v, 32'h103);
      wr(ca(0, 'h08), 32'h1);
      rd(ca(0, 'h04), v);   check("R5 dest clear", v, 32'h102);
   endtask

   task automatic t_send_ack;
      logic [31:0] v;
      wr(ca(0, 'h14), 32'h2);
      rd(ca(0, 'h14), v);   check("R7 mask readback", v, 32'h2);
      wr(ca(0, 'h10), 32'h1);
      wr(ca(0, 'h1C), 32'h8);
      rd(ca(0, 'h10), v);   check("R6 wrong trigger ignored", v, 32'h21);
      check("R6 no irq before send", irq_out, 32'h0);
      wr(ca(0, 'h1C), 32'h4);
      check("R7 masked dest vectors", irq_out, 32'h100);
      rd(ca(0, 'h10), v);   check("R6 sent status", v, 32'h01);
      pulse_ack(0);
      check("R8 owner vector on ack", irq_out, 32'h4);
      rd(ca(0, 'h10), v);   check("R8 ack status", v, 32'h81);
      wr(ca(0, 'h18), 32'h8);
      rd(ca(0, 'h10), v);   check("R9 wrong clear ignored", v, 32'h81);
      wr(ca(0, 'h18), 32'h4);
      rd(ca(0, 'h10), v);   check("R9 ready after clear", v, 32'h21);
      check("R9 ack vector dropped", irq_out, 32'h0);
   endtask

   task automatic t_manual_and_or;
      logic [31:0] v;
      wr(ca(31, 'h00), 32'h10);
      wr(ca(31, 'h04), 32'h20);
      wr(ca(31, 'h1C), 32'h10);
      check("R6 ch31 send", irq_out, 32'h20);
      pulse_ack(31);
      check("R8 ack ignored without auto", irq_out, 32'h20);
      rd(ca(31, 'h10), v);  check("R8 state held without auto", v, 32'h00);
      wr(ca(0, 'h1C), 32'h4);
      check("R11 vectors OR across channels", irq_out, 32'h120);
      wr(ca(31, 'h00), 32'h0);
      rd(ca(31, 'h10), v);  check("R4 release to idle", v, 32'h10);
      rd(ca(31, 'h00), v);  check("R4 owner cleared", v, 32'h0);
      check("R11 released channel leaves OR", irq_out, 32'h100);
   endtask

   task automatic t_msg;
      logic [31:0] v;
      for (int i = 0; i < 8; i++) wr(ca(0, 'h20 + 4*i), 32'hA5A5_0000 + 32'(i * 17));
      wr(ca(31, 'h20), 32'hDEAD_BEEF);
      for (int i = 0; i < 8; i++) begin
         rd(ca(0, 'h20 + 4*i), v);
         check("R10 message word", v, 32'hA5A5_0000 + 32'(i * 17));
      end
      rd(ca(31, 'h20), v);  check("R10 ch31 word independent", v, 32'hDEAD_BEEF);
      rd(ca(1, 'h20), v);   check("R10 untouched channel word", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock();
      t_claim_dest();
      t_send_ack();
      t_manual_and_or();
      t_msg();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule